// File: doc/BRIEF.md
# Interleaved Inner-Product Matrix Engine

The engine multiplies two 16×16 matrices of signed 16-bit fixed-point values that are held in an on-chip operand memory, and writes the 256 products of the result matrix into a separate result memory. One multiplier feeds a pipelined accumulator whose update takes 7 cycles before the same partial sum can be read again. The engine never waits on that latency. It keeps 8 independent dot products in flight and visits them in strict rotation, so each partial sum is read again exactly 8 cycles after it was last updated.

Work is split into batches. A batch is one row of the result and one group of 8 adjacent columns, which makes two batches per row and 32 per run. Within a batch, cycle t serves column slot t mod 8 at depth k = t div 8. One pulse on the start input launches a full run. The operand memory has two synchronous read ports that return data one cycle after the address is presented. The done output pulses once the final result has been written.

Top module: `mm_engine`

## Requirements
- R1: Out of reset, and at any time no run is active, rd_en_o, wr_en_o and done_o are all low.
- R2: Result element (r,c) equals the sum over k=0..15 of A[r][k]×B[k][c]. Operands are signed two's complement 16-bit values. The sum is a 40-bit two's complement value with no saturation, written with wr_addr_o = r*16+c.
- R3: On every issue cycle rd_en_o is high. The A operand is read at rda_addr_o = r*16+k and the B operand at rdb_addr_o = 256+k*16+c. The data for each address is taken from rda_data_i/rdb_data_i in the following cycle.
- R4: Issue starts in the cycle after start_i is sampled and runs for 4096 consecutive cycles. Within a batch, issue count t gives column (group*8 + t mod 8) and k = t div 8. Batches go in ascending row order, and within a row columns 0..7 come before columns 8..15.
- R5: The result of an element appears on the write port exactly 9 cycles after the issue of its k=15 product. Each batch therefore writes its 8 columns on 8 consecutive cycles in ascending column order, and there are no other writes.
- R6: A partial sum is read again exactly 8 cycles after its previous update was issued, and never while that update is still inside the 7-stage accumulate pipeline.
- R7: done_o is high for exactly one cycle per run, in the cycle after element (15,15) is written.
- R8: start_i is ignored from the cycle it is accepted until the cycle done_o is high. The issue and write sequence of the ongoing run is not disturbed.
- R9: Every batch starts its partial sums at zero, so a run that follows another run produces results that do not depend on the earlier data.
- R10: Extreme operands, such as (-32768)×(-32768) and 32767×(-32768), accumulate to the exact sum (up to ±2^34) without clipping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run (sampled while idle) |
| done_o | output | 1 | One-cycle pulse after the final result write |
| rd_en_o | output | 1 | Read strobe for both operand ports |
| rda_addr_o | output | 9 | A operand read address |
| rda_data_i | input | 16 | A operand read data, one cycle after address |
| rdb_addr_o | output | 9 | B operand read address |
| rdb_data_i | input | 16 | B operand read data, one cycle after address |
| wr_en_o | output | 1 | Result write strobe |
| wr_addr_o | output | 8 | Result write address |
| wr_data_o | output | 40 | Result write data |

## Verification
The hardest situation to bring about is a partial sum reused while the accumulate pipeline still holds entries of the previous batch or the previous run. Only a stale read or a missed clear would expose that, and only as a wrong value many cycles later. The stimulus chains four runs back to back with very different operand sets (pseudo-random values, all minimum values, maximum against minimum, and an identity matrix). Any carry-over from earlier accumulators then shows up as a wrong value rather than a value that happens to be right. A spurious start pulse is also injected in the middle of a run and just after launch, while the address and write streams are compared cycle by cycle against a behavioural model.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int unsigned MM_DIM     = 16;
  localparam int unsigned MM_LANES   = 8;
  localparam int unsigned MM_DW      = 16;
  localparam int unsigned MM_ACC_W   = 40;
  localparam int unsigned MM_ACC_LAT = 7;
endpackage

// File: rtl/mm_addr_gen.sv
module mm_addr_gen #(
  parameter int unsigned DIM    = 16,
  parameter int unsigned LANES  = 8,
  parameter int unsigned MEM_AW = 9,
  parameter int unsigned C_AW   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     launch_i,
  output logic                     rd_en_o,
  output logic [MEM_AW-1:0]        rda_addr_o,
  output logic [MEM_AW-1:0]        rdb_addr_o,
  output logic                     first_o,
  output logic                     last_o,
  output logic [$clog2(LANES)-1:0] slot_o,
  output logic [C_AW-1:0]          c_addr_o
);
  localparam int unsigned IDX_W  = $clog2(DIM);
  localparam int unsigned SLOT_W = $clog2(LANES);
  localparam int unsigned GRPS   = DIM / LANES;
  localparam int unsigned GRP_W  = $clog2(GRPS);
  localparam int unsigned B_BASE = DIM * DIM;

  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  k_q, row_q;
  logic [GRP_W-1:0]  grp_q;
  logic [IDX_W-1:0]  col;
  logic              slot_end, k_end, grp_end, row_end, last_issue;

  assign slot_end   = slot_q == SLOT_W'(LANES - 1);
  assign k_end      = k_q == IDX_W'(DIM - 1);
  assign grp_end    = grp_q == GRP_W'(GRPS - 1);
  assign row_end    = row_q == IDX_W'(DIM - 1);
  assign last_issue = slot_end && k_end && grp_end && row_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      k_q    <= '0;
      grp_q  <= '0;
      row_q  <= '0;
    end else if (!run_q) begin
      if (launch_i) begin
        run_q  <= 1'b1;
        slot_q <= '0;
        k_q    <= '0;
        grp_q  <= '0;
        row_q  <= '0;
      end
    end else begin
      slot_q <= slot_end ? '0 : slot_q + 1'b1;
      if (slot_end) begin
        k_q <= k_end ? '0 : k_q + 1'b1;
        if (k_end) begin
          grp_q <= grp_end ? '0 : grp_q + 1'b1;
          if (grp_end) row_q <= row_end ? '0 : row_q + 1'b1;
        end
      end
      if (last_issue) run_q <= 1'b0;
    end
  end

  assign col        = IDX_W'(IDX_W'(grp_q) * IDX_W'(LANES)) + IDX_W'(slot_q);
  assign rd_en_o    = run_q;
  assign rda_addr_o = MEM_AW'(row_q) * MEM_AW'(DIM) + MEM_AW'(k_q);
  assign rdb_addr_o = MEM_AW'(B_BASE) + MEM_AW'(k_q) * MEM_AW'(DIM) + MEM_AW'(col);
  assign c_addr_o   = C_AW'(row_q) * C_AW'(DIM) + C_AW'(col);
  assign first_o    = k_q == '0;
  assign last_o     = k_end;
  assign slot_o     = slot_q;

  // B region sits above A region
  assert_operand_regions_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rdb_addr_o >= MEM_AW'(B_BASE)) && (rda_addr_o < MEM_AW'(B_BASE)))
    else $error("operand address outside its region");

  // depth advances only after all slots of a sweep
  assert_slot_sweep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !slot_end) |=> $stable(k_q))
    else $error("k changed mid-sweep");
endmodule

// File: rtl/mm_mac_lane.sv
module mm_mac_lane #(
  parameter int unsigned DW      = 16,
  parameter int unsigned ACC_W   = 40,
  parameter int unsigned LANES   = 8,
  parameter int unsigned ACC_LAT = 7,
  parameter int unsigned C_AW    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic [$clog2(LANES)-1:0] slot_i,
  input  logic [C_AW-1:0]          c_addr_i,
  input  logic [DW-1:0]            a_i,
  input  logic [DW-1:0]            b_i,
  output logic                     wr_en_o,
  output logic [C_AW-1:0]          wr_addr_o,
  output logic [ACC_W-1:0]         wr_data_o
);
  localparam int unsigned PW     = 2 * DW;
  localparam int unsigned SLOT_W = $clog2(LANES);
  localparam int unsigned TAIL   = ACC_LAT - 1;

  logic signed [PW-1:0] prod_q;
  logic                 s2_vld_q, s2_first_q, s2_last_q;
  logic [SLOT_W-1:0]    s2_slot_q;
  logic [C_AW-1:0]      s2_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q   <= 1'b0;
      s2_first_q <= 1'b0;
      s2_last_q  <= 1'b0;
      s2_slot_q  <= '0;
      s2_addr_q  <= '0;
      prod_q     <= '0;
    end else begin
      s2_vld_q <= vld_i;
      if (vld_i) begin
        prod_q     <= $signed(a_i) * $signed(b_i);
        s2_first_q <= first_i;
        s2_last_q  <= last_i;
        s2_slot_q  <= slot_i;
        s2_addr_q  <= c_addr_i;
      end
    end
  end

  logic [ACC_W-1:0]        acc_q [LANES];
  logic signed [ACC_W-1:0] base, addend, sum_d;

  // first product of a batch starts from zero
  assign base   = s2_first_q ? '0 : acc_q[s2_slot_q];
  assign addend = {{(ACC_W - PW){prod_q[PW-1]}}, prod_q};
  assign sum_d  = base + addend;

  logic              dl_vld_q  [ACC_LAT];
  logic              dl_last_q [ACC_LAT];
  logic [SLOT_W-1:0] dl_slot_q [ACC_LAT];
  logic [C_AW-1:0]   dl_addr_q [ACC_LAT];
  logic [ACC_W-1:0]  dl_sum_q  [ACC_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ACC_LAT; i++) begin
        dl_vld_q[i]  <= 1'b0;
        dl_last_q[i] <= 1'b0;
        dl_slot_q[i] <= '0;
        dl_addr_q[i] <= '0;
        dl_sum_q[i]  <= '0;
      end
    end else begin
      dl_vld_q[0]  <= s2_vld_q;
      dl_last_q[0] <= s2_last_q;
      dl_slot_q[0] <= s2_slot_q;
      dl_addr_q[0] <= s2_addr_q;
      dl_sum_q[0]  <= sum_d;
      for (int i = 1; i < ACC_LAT; i++) begin
        dl_vld_q[i]  <= dl_vld_q[i-1];
        dl_last_q[i] <= dl_last_q[i-1];
        dl_slot_q[i] <= dl_slot_q[i-1];
        dl_addr_q[i] <= dl_addr_q[i-1];
        dl_sum_q[i]  <= dl_sum_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LANES; i++) acc_q[i] <= '0;
    end else if (dl_vld_q[TAIL]) begin
      acc_q[dl_slot_q[TAIL]] <= dl_sum_q[TAIL];
    end
  end

  assign wr_en_o   = dl_vld_q[TAIL] && dl_last_q[TAIL];
  assign wr_addr_o = dl_addr_q[TAIL];
  assign wr_data_o = dl_sum_q[TAIL];

  for (genvar g = 0; g < ACC_LAT; g++) begin : g_hazard
    // no partial sum is read while its update is in flight
    assert_no_stale_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s2_vld_q && !s2_first_q && dl_vld_q[g]) |-> (dl_slot_q[g] != s2_slot_q))
      else $error("stale partial sum read at stage %0d", g);
  end
endmodule

// File: rtl/mm_engine.sv
module mm_engine
  import mm_pkg::*;
#(
  parameter int unsigned DIM     = MM_DIM,
  parameter int unsigned LANES   = MM_LANES,
  parameter int unsigned DW      = MM_DW,
  parameter int unsigned ACC_W   = MM_ACC_W,
  parameter int unsigned ACC_LAT = MM_ACC_LAT,
  parameter int unsigned MEM_AW  = $clog2(2 * DIM * DIM),
  parameter int unsigned C_AW    = $clog2(DIM * DIM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [MEM_AW-1:0] rda_addr_o,
  input  logic [DW-1:0]     rda_data_i,
  output logic [MEM_AW-1:0] rdb_addr_o,
  input  logic [DW-1:0]     rdb_data_i,
  output logic              wr_en_o,
  output logic [C_AW-1:0]   wr_addr_o,
  output logic [ACC_W-1:0]  wr_data_o
);
  localparam int unsigned SLOT_W = $clog2(LANES);

  logic              busy_q, done_q, launch, final_wr;
  logic              g_first, g_last;
  logic [SLOT_W-1:0] g_slot;
  logic [C_AW-1:0]   g_addr;
  logic              s1_vld_q, s1_first_q, s1_last_q;
  logic [SLOT_W-1:0] s1_slot_q;
  logic [C_AW-1:0]   s1_addr_q;

  assign launch   = start_i && !busy_q;
  assign final_wr = wr_en_o && (wr_addr_o == C_AW'(DIM * DIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_wr;
      if (launch)        busy_q <= 1'b1;
      else if (final_wr) busy_q <= 1'b0;
    end
  end
  assign done_o = done_q;

  mm_addr_gen #(.DIM(DIM), .LANES(LANES), .MEM_AW(MEM_AW), .C_AW(C_AW)) u_gen (
    .clk_i, .rst_ni,
    .launch_i  (launch),
    .rd_en_o,
    .rda_addr_o,
    .rdb_addr_o,
    .first_o   (g_first),
    .last_o    (g_last),
    .slot_o    (g_slot),
    .c_addr_o  (g_addr)
  );

  // tags follow the one-cycle operand read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q   <= 1'b0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
      s1_slot_q  <= '0;
      s1_addr_q  <= '0;
    end else begin
      s1_vld_q   <= rd_en_o;
      s1_first_q <= g_first;
      s1_last_q  <= g_last;
      s1_slot_q  <= g_slot;
      s1_addr_q  <= g_addr;
    end
  end

  mm_mac_lane #(.DW(DW), .ACC_W(ACC_W), .LANES(LANES), .ACC_LAT(ACC_LAT), .C_AW(C_AW)) u_mac (
    .clk_i, .rst_ni,
    .vld_i     (s1_vld_q),
    .first_i   (s1_first_q),
    .last_i    (s1_last_q),
    .slot_i    (s1_slot_q),
    .c_addr_i  (s1_addr_q),
    .a_i       (rda_data_i),
    .b_i       (rdb_data_i),
    .wr_en_o,
    .wr_addr_o,
    .wr_data_o
  );

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!rd_en_o && !wr_en_o))
    else $error("activity while idle");

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

  assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_en_o))
    else $error("done without final write");
endmodule

// File: tb/mm_engine_test.sv
`timescale 1ns/1ps
module mm_engine_test;
  localparam int DIM     = 16;
  localparam int LANES   = 8;
  localparam int GRPS    = DIM / LANES;
  localparam int BBASE   = DIM * DIM;
  localparam int RUN_CYC = DIM * GRPS * DIM * LANES;
  localparam int WR_LAT  = 9;
  localparam int DONE_REL = RUN_CYC - 1 + WR_LAT + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        done_o, rd_en_o, wr_en_o;
  logic [8:0]  rda_addr_o, rdb_addr_o;
  logic [15:0] rda_data_i = '0, rdb_data_i = '0;
  logic [7:0]  wr_addr_o;
  logic [39:0] wr_data_o;

  always #2.5 clk = ~clk;

  mm_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .done_o, .rd_en_o,
    .rda_addr_o, .rda_data_i, .rdb_addr_o, .rdb_data_i,
    .wr_en_o, .wr_addr_o, .wr_data_o
  );

  logic [15:0] mem [2*DIM*DIM];
  longint      exp_c [DIM*DIM];
  always @(posedge clk) begin
    rda_data_i <= mem[rda_addr_o];
    rdb_data_i <= mem[rdb_addr_o];
  end

  int pc = 0;
  always @(posedge clk) pc <= pc + 1;

  int    checks = 0, fails = 0, dones = 0, e0 = 0;
  bit    mon_on = 1'b0, reported = 1'b0;
  string data_tag = "R2";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  endtask

  // behavioural model of the issue and write schedule
  int rel, n, row, grp, k, slot, col;
  bit exp_rd, exp_wr;
  always @(negedge clk) if (mon_on) begin
    rel = pc - e0;
    exp_rd = (rel >= 0) && (rel < RUN_CYC);
    chk(rd_en_o == exp_rd, "R4 rd_en", longint'(rd_en_o), longint'(exp_rd));
    if (exp_rd && rd_en_o) begin
      slot = rel % LANES; k = (rel / LANES) % DIM;
      grp = (rel / (LANES * DIM)) % GRPS; row = rel / (LANES * DIM * GRPS);
      col = grp * LANES + slot;
      chk(int'(rda_addr_o) == row * DIM + k, "R3 a_addr", longint'(rda_addr_o), longint'(row * DIM + k));
      chk(int'(rdb_addr_o) == BBASE + k * DIM + col, "R3 b_addr", longint'(rdb_addr_o), longint'(BBASE + k * DIM + col));
    end
    n = rel - WR_LAT;
    exp_wr = 1'b0;
    if (n >= 0 && n < RUN_CYC) begin
      slot = n % LANES; k = (n / LANES) % DIM;
      grp = (n / (LANES * DIM)) % GRPS; row = n / (LANES * DIM * GRPS);
      col = grp * LANES + slot;
      exp_wr = (k == DIM - 1);
    end
    chk(wr_en_o == exp_wr, "R5 wr_en", longint'(wr_en_o), longint'(exp_wr));
    if (exp_wr && wr_en_o) begin
      chk(int'(wr_addr_o) == row * DIM + col, "R2 wr_addr", longint'(wr_addr_o), longint'(row * DIM + col));
      // value correctness also depends on interleaved reuse (R6)
      chk(wr_data_o == 40'(exp_c[row * DIM + col]), data_tag,
          longint'($signed(wr_data_o)), exp_c[row * DIM + col]);
    end
    chk(done_o == (rel == DONE_REL), "R7 done", longint'(done_o), longint'(rel == DONE_REL));
    if (done_o) dones++;
  end

  function automatic logic [15:0] lcg(input int s);
    return 16'((s * 1103515245 + 12345) >>> 7);
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < DIM * DIM; i++) begin
      case (mode)
        0: begin mem[i] = lcg(i + 3); mem[BBASE + i] = lcg(i * 7 + 91); end
        1: begin mem[i] = 16'h8000; mem[BBASE + i] = 16'h8000; end
        2: begin mem[i] = 16'h7fff; mem[BBASE + i] = 16'h8000; end
        default: begin
          mem[i] = ((i / DIM) == (i % DIM)) ? 16'd1 : 16'd0;
          mem[BBASE + i] = lcg(i * 13 + 5);
        end
      endcase
    end
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        longint s = 0;
        for (int kk = 0; kk < DIM; kk++)
          s += longint'($signed(mem[r * DIM + kk])) * longint'($signed(mem[BBASE + kk * DIM + c]));
        exp_c[r * DIM + c] = s;
      end
  endtask

  task automatic run_engine(input int poke_at);
    @(negedge clk);
    start_i = 1'b1; e0 = pc + 1; dones = 0; mon_on = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_at > 0) begin
      // R8: extra start while busy
      repeat (poke_at) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (pc - e0 < DONE_REL + 1) @(negedge clk);
    mon_on = 1'b0;
    chk(dones == 1, "R7 R8 done count", longint'(dones), 1);
  endtask

  task automatic idle_check();
    repeat (3) begin
      @(negedge clk);
      chk(!rd_en_o && !wr_en_o && !done_o, "R1 idle",
          longint'({rd_en_o, wr_en_o, done_o}), 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!rd_en_o && !wr_en_o && !done_o, "R1 reset", longint'({rd_en_o, wr_en_o, done_o}), 0);
    rst_n = 1'b1;
    idle_check();
    fill(0); data_tag = "R2 R6 data";
    run_engine(1000);
    idle_check();
    fill(1); data_tag = "R10 min*min";
    run_engine(1);
    fill(2); data_tag = "R10 max*min";
    run_engine(0);
    fill(3); data_tag = "R9 cleared acc";
    run_engine(0);
    idle_check();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", pc, 0);
    report();
  end
endmodule